// File: doc/BRIEF.md
# Micro-Rollback Pipeline Controller

This block holds the recovery control and the one-deep input history for a five-stage in-order pipeline (fetch, decode, execute, memory, writeback). An external detector compares each pipeline register with a late-sampled copy and raises one aggregate error flag a cycle after a bad value was captured. The controller does not flush the pipeline when this happens. It rolls every stage back by one cycle and replays the work.

In every cycle where no error is flagged, each stage's selected input is written into a small history slot protected by a Hamming single-error-correcting code. The cycle in which the flag is high is the detection cycle. In that cycle the controller freezes the pipeline: all stage output registers are disabled, the memory write is blocked and the history is left unchanged. In the next cycle, the retry cycle, every stage reads its input from the corrected history copy instead of the forward path. The stream of work therefore loses exactly two cycles wherever the fault occurred.

A counter of completed rollbacks is provided so that the error rate can be observed.

Top module: `rb_ctrl`

## Requirements
- R1: While reset is held low with the error flag low, `retry_o` is 0, `sel_hist_o` is all zeros, `retry_cnt_o` is 0 and `stage_en_o` is all ones.
- R2: In a cycle that is neither a detection nor a retry cycle, `stage_in_o` equals `stage_in_i` for every stage, `stage_en_o` is all ones and `sel_hist_o` is all zeros.
- R3: In any cycle where `err_i` is 1, `stage_en_o` is all zeros and `freeze_o` is 1 in that same cycle, because both are derived combinationally from the flag.
- R4: `mem_wr_en_o` is 0 in every cycle where `err_i` is 1. In all other cycles it equals `mem_wr_req_i`, which includes the retry cycle, where the request is re-derived from restored inputs.
- R5: The cycle after a detection cycle is a retry cycle. In it, `retry_o` is 1 and `sel_hist_o` is all ones. Each stage's `stage_in_o` slice equals that stage's `stage_in_o` slice from the most recent earlier cycle with `err_i` at 0. Values presented on `stage_in_i` during the detection cycle have no effect.
- R6: A single isolated error costs exactly two cycles: the detection cycle and the retry cycle. The cycle after the retry cycle is a normal cycle (R2).
- R7: If `err_i` is 1 during a retry cycle, that cycle becomes a new detection cycle. The following cycle retries again with the same history values.
- R8: `retry_cnt_o` increments by one, modulo 2^CNT_W, at the end of each retry cycle in which `err_i` is 0. It holds its value in all other cycles.
- R9: Each history codeword uses Hamming positions 1..CW, with parity bits at the power-of-two positions and data bits at the other positions in ascending order. Readout returns the original data for every data value, with no bit of the stored codeword inverted or with any single bit inverted.
- R10: History slots reset to the data value zero. If the first cycle after reset is a detection cycle, the retry cycle presents zero on every stage slice.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pipeline clock |
| rst_n | input | 1 | Synchronous active-low reset |
| err_i | input | 1 | Aggregate register-mismatch flag from the detector |
| stage_in_i | input | NS*W | Forward-path input value of each stage, stage s in bits [s*W +: W] |
| mem_wr_req_i | input | 1 | Memory stage write request derived from its current inputs |
| stage_in_o | output | NS*W | Input value selected for each stage: forward path or corrected history |
| stage_en_o | output | NS | Output register enable per stage |
| sel_hist_o | output | NS | Per-stage input select, 1 selects the history copy |
| mem_wr_en_o | output | 1 | Gated memory write enable |
| freeze_o | output | 1 | High during a detection cycle |
| retry_o | output | 1 | High during a retry cycle |
| retry_cnt_o | output | CNT_W | Count of completed rollbacks, wrapping |

## Verification
The hardest case to reach is a single-bit upset inside a stored history codeword. From the top ports the stored bits can only ever hold valid codewords. The bench therefore drives the same encoder and decoder units that form each slot directly. It sweeps every 8-bit data value against every single-bit inversion of the 12-bit codeword. Interrupted retries are also hard to reach, so a pseudo-random run drives error bursts long enough to hit them, and enough rollbacks to wrap the counter. A reference model in the bench follows the history rule on every cycle of that run.

// File: rtl/rb_pkg.sv
// Shared definitions for the micro-rollback controller.
// Assumes codeword widths of at most 64 bits.
package rb_pkg;

    // Control state passed from the sequencer to the datapath.
    typedef struct packed {
        logic freeze;   // detection cycle: hold every register
        logic replay;   // retry cycle: feed stages from history
    } rb_ctl_t;

    // Number of Hamming parity bits needed to cover w data bits.
    function automatic int ecc_par_bits(input int w);
        int p;
        p = 1;
        while ((1 << p) < (w + p + 1)) p = p + 1;
        return p;
    endfunction

    // Mask of 1-based codeword positions checked by parity bit p.
    function automatic logic [63:0] ecc_cover(input int p);
        logic [63:0] m;
        for (int i = 0; i < 64; i++) m[i] = (((i + 1) >> p) % 2) == 1;
        return m;
    endfunction

endpackage

// File: rtl/rb_ecc_enc.sv
// Hamming single-error-correcting encoder.
// Position k (1-based) of the codeword is bit k-1. Parity sits at the
// power-of-two positions and data fills the others in ascending order.
module rb_ecc_enc #(
    parameter  int W  = 8,
    localparam int P  = rb_pkg::ecc_par_bits(W),
    localparam int CW = W + P
) (
    input  logic [W-1:0]  data_i,
    output logic [CW-1:0] code_o
);

    logic [CW-1:0] raw;   // data placed, parity positions zero

    for (genvar pos = 1; pos <= CW; pos++) begin : g_place
        if ((pos & (pos - 1)) == 0) begin : g_par_slot
            assign raw[pos-1] = 1'b0;
        end else begin : g_dat_slot
            localparam int IDX = pos - $clog2(pos + 1) - 1;
            assign raw[pos-1] = data_i[IDX];
        end
    end

    for (genvar pos = 1; pos <= CW; pos++) begin : g_out
        if ((pos & (pos - 1)) == 0) begin : g_par
            localparam int PB = $clog2(pos);
            localparam logic [63:0] COVER = rb_pkg::ecc_cover(PB);
            assign code_o[pos-1] = ^(raw & COVER[CW-1:0]);
        end else begin : g_dat
            assign code_o[pos-1] = raw[pos-1];
        end
    end

endmodule

// File: rtl/rb_ecc_dec.sv
// Hamming single-error-correcting decoder matching rb_ecc_enc.
// Assumes at most one inverted bit; a non-zero syndrome names the 1-based
// position to flip back.
module rb_ecc_dec #(
    parameter  int W  = 8,
    localparam int P  = rb_pkg::ecc_par_bits(W),
    localparam int CW = W + P
) (
    input  logic [CW-1:0] code_i,
    output logic [W-1:0]  data_o
);

    logic [P-1:0]  syn;
    logic [CW-1:0] fix;

    for (genvar p = 0; p < P; p++) begin : g_syn
        localparam logic [63:0] COVER = rb_pkg::ecc_cover(p);
        assign syn[p] = ^(code_i & COVER[CW-1:0]);
    end

    for (genvar pos = 1; pos <= CW; pos++) begin : g_fix
        assign fix[pos-1] = code_i[pos-1] ^ (syn == P'(pos));
        if ((pos & (pos - 1)) != 0) begin : g_dat
            localparam int IDX = pos - $clog2(pos + 1) - 1;
            assign data_o[IDX] = fix[pos-1];
        end
    end

endmodule

// File: rtl/rb_hist_slot.sv
// One-deep history slot for a single stage: stores the encoded input value
// and returns it corrected. Reset leaves the code for data zero.
module rb_hist_slot #(
    parameter  int W  = 8,
    localparam int P  = rb_pkg::ecc_par_bits(W),
    localparam int CW = W + P
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] rd_data
);

    logic [CW-1:0] enc_code;
    logic [CW-1:0] code_q;

    rb_ecc_enc #(.W(W)) enc_i (.data_i(wr_data), .code_o(enc_code));

    // Capture the encoded input whenever the pipeline advances.
    always_ff @(posedge clk) begin
        if (!rst_n)     code_q <= '0;
        else if (wr_en) code_q <= enc_code;
    end

    rb_ecc_dec #(.W(W)) dec_i (.code_i(code_q), .data_o(rd_data));

endmodule

// File: rtl/rb_seq.sv
// Rollback sequencer: turns the aggregate error flag into freeze and
// replay controls and counts completed rollbacks.
// Assumes the error flag arrives exactly one cycle after the bad capture.
module rb_seq #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             err_i,
    output rb_pkg::rb_ctl_t  ctl_o,
    output logic [CNT_W-1:0] cnt_o
);

    logic replay_q;

    // Any detection cycle is followed by a retry cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) replay_q <= 1'b0;
        else        replay_q <= err_i;
    end

    // Count retry cycles that complete without a new error.
    always_ff @(posedge clk) begin
        if (!rst_n)                 cnt_o <= '0;
        else if (replay_q && !err_i) cnt_o <= cnt_o + 1'b1;
    end

    // Freeze is combinational on the flag; replay is the registered state.
    always_comb begin
        ctl_o.freeze = err_i;
        ctl_o.replay = replay_q;
    end

endmodule

// File: rtl/rb_ctrl.sv
// Micro-rollback pipeline controller (top).
// Freezes every stage in the cycle the aggregate error flag is high, then
// replays one cycle from ECC-protected per-stage history. Stage s uses
// bits [s*W +: W] of the stage buses.
module rb_ctrl #(
    parameter int NS    = 5,
    parameter int W     = 8,
    parameter int CNT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              err_i,
    input  logic [NS*W-1:0]   stage_in_i,
    input  logic              mem_wr_req_i,
    output logic [NS*W-1:0]   stage_in_o,
    output logic [NS-1:0]     stage_en_o,
    output logic [NS-1:0]     sel_hist_o,
    output logic              mem_wr_en_o,
    output logic              freeze_o,
    output logic              retry_o,
    output logic [CNT_W-1:0]  retry_cnt_o
);

    rb_pkg::rb_ctl_t ctl;

    rb_seq #(.CNT_W(CNT_W)) seq_i (
        .clk   (clk),
        .rst_n (rst_n),
        .err_i (err_i),
        .ctl_o (ctl),
        .cnt_o (retry_cnt_o)
    );

    for (genvar s = 0; s < NS; s++) begin : g_stage
        logic [W-1:0] hist_val;

        rb_hist_slot #(.W(W)) slot_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (!ctl.freeze),
            .wr_data (stage_in_o[s*W +: W]),
            .rd_data (hist_val)
        );

        // Select the stage input: corrected history on retry, else forward.
        always_comb begin
            stage_in_o[s*W +: W] = ctl.replay ? hist_val : stage_in_i[s*W +: W];
            stage_en_o[s]        = !ctl.freeze;
            sel_hist_o[s]        = ctl.replay;
        end
    end

    // Block the memory write for the whole detection cycle.
    always_comb begin
        mem_wr_en_o = mem_wr_req_i && !ctl.freeze;
        freeze_o    = ctl.freeze;
        retry_o     = ctl.replay;
    end

endmodule

// File: rtl/rb_ctrl_chk.sv
// Assertion checker for rb_ctrl, bound to every instance below.
// Assumes its ports mirror the controller's ports.
module rb_ctrl_chk #(
    parameter int NS    = 5,
    parameter int W     = 8,
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             err_i,
    input logic [NS*W-1:0]  stage_in_o,
    input logic [NS-1:0]    stage_en_o,
    input logic [NS-1:0]    sel_hist_o,
    input logic             mem_wr_en_o,
    input logic             retry_o,
    input logic [CNT_W-1:0] retry_cnt_o
);

    logic [1:0] cyc_q;   // cycles since reset release, saturating

    // Track how far back $past may safely look.
    always_ff @(posedge clk) begin
        if (!rst_n)          cyc_q <= '0;
        else if (cyc_q != 2'd3) cyc_q <= cyc_q + 2'd1;
    end

    a_r3_freeze_now: assert property (@(posedge clk) disable iff (!rst_n)
        err_i |-> (stage_en_o == '0));

    a_r4_mem_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        err_i |-> !mem_wr_en_o);

    a_r5_retry_follows: assert property (@(posedge clk) disable iff (!rst_n)
        err_i |=> (retry_o && sel_hist_o == '1));

    a_r5_replay_value: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_q >= 2'd2 && retry_o && !$past(retry_o)) |-> (stage_in_o == $past(stage_in_o, 2)));

    a_r6_back_to_normal: assert property (@(posedge clk) disable iff (!rst_n)
        (retry_o && !err_i) |=> (!retry_o && sel_hist_o == '0));

    a_r8_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (retry_o && !err_i) |=> (retry_cnt_o == $past(retry_cnt_o) + 1'b1));

    a_r8_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(retry_o && !err_i) |=> $stable(retry_cnt_o));

endmodule

bind rb_ctrl rb_ctrl_chk #(.NS(NS), .W(W), .CNT_W(CNT_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .err_i       (err_i),
    .stage_in_o  (stage_in_o),
    .stage_en_o  (stage_en_o),
    .sel_hist_o  (sel_hist_o),
    .mem_wr_en_o (mem_wr_en_o),
    .retry_o     (retry_o),
    .retry_cnt_o (retry_cnt_o)
);

// File: tb/rb_ctrl_tb_top.sv
// Self-checking bench: exhaustive codec sweep plus cycle-accurate model run.
module rb_ctrl_tb_top;

    localparam int CLK_P = 10;
    localparam int NS    = 5;
    localparam int W     = 8;
    localparam int CNT_W = 8;
    localparam int CW    = W + rb_pkg::ecc_par_bits(W);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              err_i = 1'b0;
    logic [NS*W-1:0]   stage_in_i = '0;
    logic              mem_wr_req_i = 1'b0;
    logic [NS*W-1:0]   stage_in_o;
    logic [NS-1:0]     stage_en_o;
    logic [NS-1:0]     sel_hist_o;
    logic              mem_wr_en_o;
    logic              freeze_o;
    logic              retry_o;
    logic [CNT_W-1:0]  retry_cnt_o;

    // Codec under sweep
    logic [W-1:0]  cd_in = '0;
    logic [CW-1:0] cd_code;
    logic [CW-1:0] cd_flip = '0;
    logic [CW-1:0] cd_bad;
    logic [W-1:0]  cd_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Reference model state
    logic [NS*W-1:0]  m_hist;
    logic [CNT_W-1:0] m_cnt;
    bit m_prev_err, m_prev_retry, m_prev_done, m_hist_rst;
    logic [31:0] lfsr = 32'h1D2C_3B4A;

    always #(CLK_P/2) clk = ~clk;

    rb_ctrl #(.NS(NS), .W(W), .CNT_W(CNT_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .err_i(err_i), .stage_in_i(stage_in_i),
        .mem_wr_req_i(mem_wr_req_i), .stage_in_o(stage_in_o),
        .stage_en_o(stage_en_o), .sel_hist_o(sel_hist_o),
        .mem_wr_en_o(mem_wr_en_o), .freeze_o(freeze_o), .retry_o(retry_o),
        .retry_cnt_o(retry_cnt_o)
    );

    rb_ecc_enc #(.W(W)) cd_enc_i (.data_i(cd_in), .code_o(cd_code));
    assign cd_bad = cd_code ^ cd_flip;
    rb_ecc_dec #(.W(W)) cd_dec_i (.code_i(cd_bad), .data_o(cd_out));

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] nxt(input logic [31:0] v);
        logic [31:0] x;
        x = v ^ (v << 13);
        x = x ^ (x >> 17);
        x = x ^ (x << 5);
        return x;
    endfunction

    // Hold reset for a few cycles; checks R1 and resets the model.
    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; err_i = 1'b0; mem_wr_req_i = 1'b0;
        repeat (2) @(negedge clk);
        #1;
        check(retry_o == 1'b0, "R1", "retry_o in reset", 64'(retry_o), 64'd0);
        check(sel_hist_o == '0, "R1", "sel_hist_o in reset", 64'(sel_hist_o), 64'd0);
        check(retry_cnt_o == '0, "R1", "retry_cnt_o in reset", 64'(retry_cnt_o), 64'd0);
        check(stage_en_o == '1, "R1", "stage_en_o in reset", 64'(stage_en_o), 64'h1f);
        @(negedge clk);
        rst_n = 1'b1;
        m_hist = '0; m_cnt = '0; m_prev_err = 0; m_prev_retry = 0;
        m_prev_done = 0; m_hist_rst = 1;
    endtask

    // One cycle: drive at negedge, check 1 time unit later, advance model.
    task automatic step(input bit err, input bit req, input logic [NS*W-1:0] din);
        bit exp_retry;
        logic [NS*W-1:0] exp_out;
        string t_sel, t_dat, t_en;
        err_i = err; mem_wr_req_i = req; stage_in_i = din;
        #1;
        exp_retry = m_prev_err;
        exp_out   = exp_retry ? m_hist : din;
        t_en  = err ? (exp_retry ? "R7" : "R3") : "R2";
        t_sel = exp_retry ? "R5" : (m_prev_done ? "R6" : "R2");
        t_dat = exp_retry ? (m_hist_rst ? "R10" : (m_prev_retry ? "R7" : "R5"))
                          : (m_prev_done ? "R6" : "R2");
        check(stage_en_o == (err ? '0 : '1), t_en, "stage_en_o", 64'(stage_en_o), err ? 64'd0 : 64'h1f);
        check(freeze_o == err, "R3", "freeze_o", 64'(freeze_o), 64'(err));
        check(mem_wr_en_o == (req && !err), "R4", "mem_wr_en_o", 64'(mem_wr_en_o), 64'(req && !err));
        check(retry_o == exp_retry, t_sel, "retry_o", 64'(retry_o), 64'(exp_retry));
        check(sel_hist_o == {NS{exp_retry}}, t_sel, "sel_hist_o", 64'(sel_hist_o), 64'({NS{exp_retry}}));
        check(stage_in_o == exp_out, t_dat, "stage_in_o", 64'(stage_in_o), 64'(exp_out));
        check(retry_cnt_o == m_cnt, "R8", "retry_cnt_o", 64'(retry_cnt_o), 64'(m_cnt));
        if (!err) begin
            m_hist = exp_out;
            m_hist_rst = 0;
        end
        if (exp_retry && !err) m_cnt = m_cnt + 1'b1;
        m_prev_done  = exp_retry && !err;
        m_prev_retry = exp_retry;
        m_prev_err   = err;
        @(negedge clk);
    endtask

    function automatic logic [NS*W-1:0] rnd_data();
        lfsr = nxt(lfsr);
        rnd_data[31:0] = lfsr;
        lfsr = nxt(lfsr);
        rnd_data[NS*W-1:32] = lfsr[NS*W-33:0];
    endfunction

    initial begin
        // R9: every data value against every single-bit inversion (or none)
        for (int d = 0; d < (1 << W); d++) begin
            for (int f = 0; f <= CW; f++) begin
                cd_in = W'(d);
                cd_flip = '0;
                if (f < CW) cd_flip[f] = 1'b1;
                #1;
                check(cd_out == W'(d), "R9", "corrected readout", 64'(cd_out), 64'(d));
            end
        end

        // R1 then R10: detection in the first cycle after reset replays zero
        do_reset();
        step(1'b1, 1'b1, rnd_data());
        step(1'b0, 1'b1, rnd_data());
        step(1'b0, 1'b0, rnd_data());

        // R2 normal run, then R5/R6 isolated single errors
        do_reset();
        for (int i = 0; i < 6; i++) step(1'b0, i[0], rnd_data());
        for (int k = 0; k < 4; k++) begin
            step(1'b0, 1'b1, rnd_data());
            step(1'b1, 1'b1, rnd_data());
            step(1'b0, 1'b1, rnd_data());
            step(1'b0, 1'b0, rnd_data());
        end
        // R7: error again in the retry cycle, and longer bursts
        for (int len = 2; len <= 5; len++) begin
            step(1'b0, 1'b1, rnd_data());
            for (int j = 0; j < len; j++) step(1'b1, 1'b1, rnd_data());
            step(1'b0, 1'b1, rnd_data());
            step(1'b0, 1'b1, rnd_data());
        end
        // Alternating errors and retries
        for (int i = 0; i < 8; i++) step(i[0], 1'b1, rnd_data());

        // Random run: bursty errors, enough rollbacks to wrap the counter (R8)
        for (int i = 0; i < 3000; i++) begin
            bit e;
            lfsr = nxt(lfsr);
            e = (lfsr[1:0] == 2'd0) || (lfsr[7:4] == 4'd0 && m_prev_err);
            step(e, lfsr[9], rnd_data());
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule